// File: doc/BRIEF.md
# Console Bus and I/O Port Decoder

This block sits between the 8-bit CPU of a small game console and everything the CPU can reach. On the memory side it steers each access either to the cartridge, which gets first claim through a hit flag, or to an internal work RAM. That RAM occupies the top quarter of the 64 KiB space and repeats every 2^RAM_AW bytes inside that window. Addresses below the window that the cartridge does not claim are open: writes vanish and reads return 0xFF.

On the I/O side the block splits the 256-entry port space into four regions using the top two port address bits. Those regions lead to the video beam counters, the video data, status and control ports, the sound generator and the controller inputs. A static mode pin selects between a home console variant and a handheld variant. The handheld variant adds a start button, a stereo balance register at port 0x06 and a rule that cancels opposite direction presses. All read data is combinational from the address. The only clocked state is the RAM and the balance register.

Top module: `console_bus_decoder`

## Requirements
- R1: When `cart_hit` is high, `mem_rdata` equals `cart_rdata`, `cart_we` follows `mem_wr`, and the work RAM is not written.
- R2: Without a cartridge hit, an address at or above 0xC000 reads and writes the work RAM at index `mem_addr[RAM_AW-1:0]`, so every copy in the window aliases the same byte. A write lands on the rising clock edge while `mem_wr` is high.
- R3: Without a cartridge hit, an address below 0xC000 reads 0xFF and a write to it changes no RAM byte.
- R4: Port region 1 (port bits [7:6] = 01): a read returns `vcount` when port bit 0 is 0 and `hcount` when it is 1. Any write pulses `psg_we`.
- R5: Port region 2 (bits [7:6] = 10): with bit 0 = 0, a read returns `vdp_rdata` and pulses `vdp_data_rd`, and a write pulses `vdp_data_we`. With bit 0 = 1, a read returns `vdp_status` and pulses `vdp_status_rd`, and a write pulses `vdp_ctrl_we`.
- R6: Home mode, region 3, even port: the read byte is {~pad2[1:0], ~pad1[5:0]}. Pad bits are active-high pressed, in the order up, down, left, right, button 1, button 2, with the extra line at bit 6.
- R7: Home mode, region 3, odd port: the read byte is {~pad2[6], ~pad1[6], 1, ~reset_btn, ~pad2[5:2]}.
- R8: `balance` resets to 0xFF. A write to port 0x06 loads it from `io_wdata` on the clock edge in handheld mode only. In home mode that write leaves it unchanged.
- R9: Region 0 reads return {~start_btn, 7'h7F} in handheld mode and 0xFF in home mode.
- R10: Handheld mode, region 3: an even port reads {2'b11, ~b2, ~b1, ~right, ~left, ~down, ~up}, taken from `hh_btn[5:0]` in the order up, down, left, right, button 1, button 2. An odd port reads 0xFF.
- R11: Handheld mode: when up and down are both pressed, both read as released (1). The same holds for left and right.
- R12: Writes to region 3, and to region 0 other than the handheld balance port, raise no write strobe and leave `balance` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| handheld | input | 1 | Static mode: 1 handheld, 0 home console |
| mem_addr | input | 16 | CPU memory address |
| mem_wdata | input | 8 | CPU memory write data |
| mem_wr | input | 1 | CPU memory write strobe |
| mem_rdata | output | 8 | Memory read data |
| cart_hit | input | 1 | Cartridge claims the current memory address |
| cart_rdata | input | 8 | Cartridge read data |
| cart_we | output | 1 | Write strobe to cartridge |
| io_addr | input | 8 | CPU port address |
| io_wdata | input | 8 | CPU port write data |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_rdata | output | 8 | Port read data |
| vcount | input | 8 | Video vertical counter |
| hcount | input | 8 | Video horizontal counter |
| vdp_rdata | input | 8 | Video data port read value |
| vdp_status | input | 8 | Video status value |
| vdp_data_rd | output | 1 | Video data port read pulse |
| vdp_status_rd | output | 1 | Video status read pulse |
| vdp_data_we | output | 1 | Video data port write pulse |
| vdp_ctrl_we | output | 1 | Video control write pulse |
| psg_we | output | 1 | Sound generator write pulse |
| balance | output | 8 | Stereo balance register |
| pad1 | input | 7 | Pad 1 buttons, active-high pressed |
| pad2 | input | 7 | Pad 2 buttons, active-high pressed |
| reset_btn | input | 1 | Home console reset button, active-high pressed |
| hh_btn | input | 6 | Handheld buttons, active-high pressed |
| start_btn | input | 1 | Handheld start button, active-high pressed |

## Verification
The bench builds the block with RAM_AW = 10. That shrinks the work RAM to 1 KiB, so the 16 KiB window holds sixteen copies and aliasing is easy to reach. A write near the bottom of the window can be read back near the top, and the highest address folds onto the last RAM index. The default 16-bit address width and 0xC000 base are kept, so the open region below the window and the cartridge priority are exercised at their real boundaries. Both modes are driven on the same instance by switching the static mode pin between phases.

// File: rtl/cbd_pkg.sv
// Shared constants and types for the console bus decoder.
// Assumes an 8-bit data path and an 8-bit port address space.
package cbd_pkg;
    localparam logic [7:0] OPEN_BUS = 8'hFF;

    // Port regions selected by port address bits [7:6]
    typedef enum logic [1:0] {
        RGN_MISC   = 2'd0,
        RGN_BEAM   = 2'd1,
        RGN_VIDEO  = 2'd2,
        RGN_INPUTS = 2'd3
    } region_e;

    // Button index order for directional groups
    localparam int BTN_UP    = 0;
    localparam int BTN_DOWN  = 1;
    localparam int BTN_LEFT  = 2;
    localparam int BTN_RIGHT = 3;
    localparam int BTN_ONE   = 4;
    localparam int BTN_TWO   = 5;
endpackage

// File: rtl/cbd_mem_map.sv
// Memory side of the decoder: cartridge priority, mirrored work RAM and
// the open region below the RAM window.
// Assumes the cartridge hit flag is valid combinationally for mem_addr.
module cbd_mem_map #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 11,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_wr,
    input  logic              cart_hit,
    input  logic [DATA_W-1:0] cart_rdata,
    output logic              cart_we,
    output logic [DATA_W-1:0] mem_rdata
);
    import cbd_pkg::*;

    localparam int RAM_DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] ram_q [RAM_DEPTH];
    logic              in_window;
    logic [RAM_AW-1:0] ram_idx;
    logic              ram_we;

    // Address classification and RAM index fold
    always_comb begin
        in_window = (mem_addr >= RAM_BASE);
        ram_idx   = mem_addr[RAM_AW-1:0];
        ram_we    = mem_wr && !cart_hit && in_window;
        cart_we   = mem_wr && cart_hit;
    end

    // Work RAM write port, lands on the clock edge
    always_ff @(posedge clk) begin
        if (ram_we) begin
            ram_q[ram_idx] <= mem_wdata;
        end
    end

    // Read data selection: cartridge first, then RAM, else open bus
    always_comb begin
        if (cart_hit) begin
            mem_rdata = cart_rdata;
        end else if (in_window) begin
            mem_rdata = ram_q[ram_idx];
        end else begin
            mem_rdata = DATA_W'(OPEN_BUS);
        end
    end

    // R2: a RAM write is visible at its index on the next cycle
    p_ram_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (ram_q[$past(ram_idx)] == $past(mem_wdata)));

    // R1: a cartridge-claimed write never reaches the RAM
    p_cart_blocks_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_hit && mem_wr) |-> (cart_we && !ram_we));
endmodule

// File: rtl/cbd_pad_pack.sv
// Builds the controller bytes for port region 3 and the region 0 byte.
// Assumes all button inputs are active-high pressed and static over an access.
module cbd_pad_pack #(
    parameter int PAD_W = 7,
    parameter int HH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             handheld,
    input  logic             odd_port,
    input  logic [PAD_W-1:0] pad1,
    input  logic [PAD_W-1:0] pad2,
    input  logic             reset_btn,
    input  logic [HH_W-1:0]  hh_btn,
    input  logic             start_btn,
    output logic [7:0]       inputs_byte,
    output logic [7:0]       misc_byte
);
    import cbd_pkg::*;

    logic [7:0]      home_even;
    logic [7:0]      home_odd;
    logic [7:0]      hh_even;
    logic [HH_W-1:0] hh_eff;

    // Home console packing across the two pad ports
    always_comb begin
        home_even = {~pad2[1:0], ~pad1[5:0]};
        home_odd  = {~pad2[6], ~pad1[6], 1'b1, ~reset_btn, ~pad2[5:2]};
    end

    // Handheld opposite-direction cancel, then active-low packing
    always_comb begin
        hh_eff = hh_btn;
        if (hh_btn[BTN_UP] && hh_btn[BTN_DOWN]) begin
            hh_eff[BTN_UP]   = 1'b0;
            hh_eff[BTN_DOWN] = 1'b0;
        end
        if (hh_btn[BTN_LEFT] && hh_btn[BTN_RIGHT]) begin
            hh_eff[BTN_LEFT]  = 1'b0;
            hh_eff[BTN_RIGHT] = 1'b0;
        end
        hh_even = {2'b11, ~hh_eff[5:0]};
    end

    // Region 3 byte by mode and port parity
    always_comb begin
        if (handheld) begin
            inputs_byte = odd_port ? OPEN_BUS : hh_even;
        end else begin
            inputs_byte = odd_port ? home_odd : home_even;
        end
    end

    // Region 0 byte: start button only in handheld mode
    always_comb begin
        misc_byte = handheld ? {~start_btn, 7'h7F} : OPEN_BUS;
    end

    // R11: up and down together always read released in handheld mode
    p_vert_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (handheld && !odd_port && hh_btn[BTN_UP] && hh_btn[BTN_DOWN])
            |-> (inputs_byte[1:0] == 2'b11));

    // R11: left and right together always read released in handheld mode
    p_horz_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (handheld && !odd_port && hh_btn[BTN_LEFT] && hh_btn[BTN_RIGHT])
            |-> (inputs_byte[3:2] == 2'b11));
endmodule

// File: rtl/cbd_port_decode.sv
// Port side of the decoder: region select, write and read strobes,
// read data mux and the handheld stereo balance register.
// Assumes io_rd and io_wr are never high together.
module cbd_port_decode #(
    parameter logic [7:0] BAL_PORT  = 8'h06,
    parameter logic [7:0] BAL_RESET = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       handheld,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] vcount,
    input  logic [7:0] hcount,
    input  logic [7:0] vdp_rdata,
    input  logic [7:0] vdp_status,
    input  logic [7:0] inputs_byte,
    input  logic [7:0] misc_byte,
    output logic [7:0] io_rdata,
    output logic       vdp_data_rd,
    output logic       vdp_status_rd,
    output logic       vdp_data_we,
    output logic       vdp_ctrl_we,
    output logic       psg_we,
    output logic [7:0] balance
);
    import cbd_pkg::*;

    region_e rgn;
    logic    odd;
    logic    bal_load;

    // Region and parity extraction
    always_comb begin
        rgn = region_e'(io_addr[7:6]);
        odd = io_addr[0];
    end

    // Write strobes; the balance port is checked ahead of region decode
    always_comb begin
        bal_load    = 1'b0;
        psg_we      = 1'b0;
        vdp_data_we = 1'b0;
        vdp_ctrl_we = 1'b0;
        if (io_wr) begin
            if (handheld && (io_addr == BAL_PORT)) begin
                bal_load = 1'b1;
            end else begin
                unique case (rgn)
                    RGN_BEAM:   psg_we = 1'b1;
                    RGN_VIDEO: begin
                        vdp_data_we = !odd;
                        vdp_ctrl_we = odd;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read strobes for video ports with side effects
    always_comb begin
        vdp_data_rd   = io_rd && (rgn == RGN_VIDEO) && !odd;
        vdp_status_rd = io_rd && (rgn == RGN_VIDEO) && odd;
    end

    // Read data mux by region
    always_comb begin
        unique case (rgn)
            RGN_MISC:   io_rdata = misc_byte;
            RGN_BEAM:   io_rdata = odd ? hcount : vcount;
            RGN_VIDEO:  io_rdata = odd ? vdp_status : vdp_rdata;
            RGN_INPUTS: io_rdata = inputs_byte;
            default:    io_rdata = OPEN_BUS;
        endcase
    end

    // Stereo balance register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            balance <= BAL_RESET;
        end else if (bal_load) begin
            balance <= io_wdata;
        end
    end

    // R8: balance takes the written byte on the following cycle
    p_bal_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bal_load |=> (balance == $past(io_wdata)));

    // R8: balance holds when no balance write is made
    p_bal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && handheld && (io_addr == BAL_PORT)) |=> $stable(balance));

    // R12: at most one write target per access
    p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bal_load, psg_we, vdp_data_we, vdp_ctrl_we}));

    // R12: region 3 writes raise no strobe
    p_inputs_wr_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[7:6] == 2'b11) |-> !(psg_we || vdp_data_we || vdp_ctrl_we || bal_load));
endmodule

// File: rtl/console_bus_decoder.sv
// Top of the console bus and I/O decoder. Joins the memory map, the
// port decoder and the controller packing. Assumes a static mode pin.
module console_bus_decoder #(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 11,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'hC000,
    parameter logic [7:0] BAL_PORT  = 8'h06,
    parameter logic [7:0] BAL_RESET = 8'hFF,
    parameter int PAD_W = 7,
    parameter int HH_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handheld,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic              mem_wr,
    output logic [7:0]        mem_rdata,
    input  logic              cart_hit,
    input  logic [7:0]        cart_rdata,
    output logic              cart_we,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic [7:0]        vcount,
    input  logic [7:0]        hcount,
    input  logic [7:0]        vdp_rdata,
    input  logic [7:0]        vdp_status,
    output logic              vdp_data_rd,
    output logic              vdp_status_rd,
    output logic              vdp_data_we,
    output logic              vdp_ctrl_we,
    output logic              psg_we,
    output logic [7:0]        balance,
    input  logic [PAD_W-1:0]  pad1,
    input  logic [PAD_W-1:0]  pad2,
    input  logic              reset_btn,
    input  logic [HH_W-1:0]   hh_btn,
    input  logic              start_btn
);
    logic [7:0] inputs_byte;
    logic [7:0] misc_byte;

    cbd_mem_map #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (8),
        .RAM_AW  (RAM_AW),
        .RAM_BASE(RAM_BASE)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wr    (mem_wr),
        .cart_hit  (cart_hit),
        .cart_rdata(cart_rdata),
        .cart_we   (cart_we),
        .mem_rdata (mem_rdata)
    );

    cbd_pad_pack #(
        .PAD_W(PAD_W),
        .HH_W (HH_W)
    ) u_pads (
        .clk        (clk),
        .rst_n      (rst_n),
        .handheld   (handheld),
        .odd_port   (io_addr[0]),
        .pad1       (pad1),
        .pad2       (pad2),
        .reset_btn  (reset_btn),
        .hh_btn     (hh_btn),
        .start_btn  (start_btn),
        .inputs_byte(inputs_byte),
        .misc_byte  (misc_byte)
    );

    cbd_port_decode #(
        .BAL_PORT (BAL_PORT),
        .BAL_RESET(BAL_RESET)
    ) u_ports (
        .clk          (clk),
        .rst_n        (rst_n),
        .handheld     (handheld),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .vcount       (vcount),
        .hcount       (hcount),
        .vdp_rdata    (vdp_rdata),
        .vdp_status   (vdp_status),
        .inputs_byte  (inputs_byte),
        .misc_byte    (misc_byte),
        .io_rdata     (io_rdata),
        .vdp_data_rd  (vdp_data_rd),
        .vdp_status_rd(vdp_status_rd),
        .vdp_data_we  (vdp_data_we),
        .vdp_ctrl_we  (vdp_ctrl_we),
        .psg_we       (psg_we),
        .balance      (balance)
    );
endmodule

// File: tb/console_bus_decoder_tb_top.sv
// Scoreboard bench: the driver applies stimulus and queues expected bytes,
// the monitor compares them against the ports one time unit later.
module console_bus_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_MEM = 0;
    localparam int SEL_IO  = 1;
    localparam int SEL_BAL = 2;
    localparam int SEL_STB = 3;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic handheld = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        mem_wr = 1'b0;
    logic [7:0]  mem_rdata;
    logic        cart_hit = 1'b0;
    logic [7:0]  cart_rdata = '0;
    logic        cart_we;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [7:0]  vcount = 8'h12;
    logic [7:0]  hcount = 8'h34;
    logic [7:0]  vdp_rdata = 8'hA5;
    logic [7:0]  vdp_status = 8'h81;
    logic vdp_data_rd, vdp_status_rd, vdp_data_we, vdp_ctrl_we, psg_we;
    logic [7:0]  balance;
    logic [6:0]  pad1 = '0;
    logic [6:0]  pad2 = '0;
    logic        reset_btn = 1'b0;
    logic [5:0]  hh_btn = '0;
    logic        start_btn = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    item_t sb_q[$];
    event sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_bus_decoder #(.RAM_AW(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .handheld(handheld),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .cart_hit(cart_hit), .cart_rdata(cart_rdata),
        .cart_we(cart_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .vcount(vcount), .hcount(hcount), .vdp_rdata(vdp_rdata),
        .vdp_status(vdp_status), .vdp_data_rd(vdp_data_rd),
        .vdp_status_rd(vdp_status_rd), .vdp_data_we(vdp_data_we),
        .vdp_ctrl_we(vdp_ctrl_we), .psg_we(psg_we), .balance(balance),
        .pad1(pad1), .pad2(pad2), .reset_btn(reset_btn),
        .hh_btn(hh_btn), .start_btn(start_btn)
    );

    // Strobe vector: {cart_we, psg_we, vdp_data_we, vdp_ctrl_we, vdp_data_rd, vdp_status_rd, 0, 0}
    function automatic logic [7:0] strobes();
        return {cart_we, psg_we, vdp_data_we, vdp_ctrl_we, vdp_data_rd, vdp_status_rd, 2'b00};
    endfunction

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_MEM: act = mem_rdata;
                    SEL_IO:  act = io_rdata;
                    SEL_BAL: act = balance;
                    default: act = strobes();
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver side: queue one expectation and hand it to the monitor
    task automatic expect_item(string tag, int sel, logic [7:0] exp);
        item_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        #1;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic idle_bus();
        mem_wr = 1'b0; io_wr = 1'b0; io_rd = 1'b0; cart_hit = 1'b0;
    endtask

    task automatic mem_write(logic [15:0] a, logic [7:0] d, logic hit);
        @(negedge clk);
        idle_bus();
        mem_addr = a; mem_wdata = d; mem_wr = 1'b1; cart_hit = hit;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic mem_read(string tag, logic [15:0] a, logic hit, logic [7:0] exp);
        @(negedge clk);
        idle_bus();
        mem_addr = a; cart_hit = hit;
        expect_item(tag, SEL_MEM, exp);
    endtask

    task automatic io_read(string tag, logic [7:0] a, logic [7:0] exp_data, logic [7:0] exp_stb);
        @(negedge clk);
        idle_bus();
        io_addr = a; io_rd = 1'b1;
        expect_item(tag, SEL_IO, exp_data);
        expect_item(tag, SEL_STB, exp_stb);
    endtask

    task automatic io_write(string tag, logic [7:0] a, logic [7:0] d, logic [7:0] exp_stb);
        @(negedge clk);
        idle_bus();
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        expect_item(tag, SEL_STB, exp_stb);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R8): balance 0xFF, no strobes
        @(negedge clk);
        expect_item("R8 reset balance", SEL_BAL, 8'hFF);
        expect_item("R12 idle strobes", SEL_STB, 8'h00);

        // R2: write in window, read through mirrors (RAM_AW = 10)
        mem_write(16'hC005, 8'h5A, 1'b0);
        mem_read("R2 direct", 16'hC005, 1'b0, 8'h5A);
        mem_read("R2 mirror C405", 16'hC405, 1'b0, 8'h5A);
        mem_read("R2 mirror FC05", 16'hFC05, 1'b0, 8'h5A);
        mem_write(16'hFFFF, 8'hE1, 1'b0);
        mem_read("R2 top folds", 16'hC3FF, 1'b0, 8'hE1);

        // R3: below window writes dropped, reads open
        mem_write(16'hC000, 8'h11, 1'b0);
        mem_write(16'h8000, 8'h99, 1'b0);
        mem_read("R3 no alias write", 16'hC000, 1'b0, 8'h11);
        mem_read("R3 open read", 16'h8000, 1'b0, 8'hFF);
        mem_read("R3 edge BFFF", 16'hBFFF, 1'b0, 8'hFF);

        // R1: cartridge priority on reads and writes
        cart_rdata = 8'h3C;
        mem_read("R1 cart read", 16'hC005, 1'b1, 8'h3C);
        @(negedge clk);
        idle_bus();
        mem_addr = 16'hC005; mem_wdata = 8'h77; mem_wr = 1'b1; cart_hit = 1'b1;
        expect_item("R1 cart strobe", SEL_STB, 8'h80);
        @(negedge clk);
        idle_bus();
        mem_read("R1 RAM untouched", 16'hC005, 1'b0, 8'h5A);

        // R4: beam counters and sound writes
        io_read("R4 vcount", 8'h7E, 8'h12, 8'h00);
        io_read("R4 hcount", 8'h7F, 8'h34, 8'h00);
        io_write("R4 psg write", 8'h7F, 8'h9F, 8'h40);

        // R5: video data, status and control
        io_read("R5 data read", 8'hBE, 8'hA5, 8'h08);
        io_read("R5 status read", 8'hBF, 8'h81, 8'h04);
        io_write("R5 data write", 8'hBE, 8'h00, 8'h20);
        io_write("R5 ctrl write", 8'hBF, 8'h00, 8'h10);

        // R9: home mode region 0 reads 0xFF
        start_btn = 1'b1;
        io_read("R9 home misc", 8'h00, 8'hFF, 8'h00);

        // R6 and R7: home pad packing
        pad1 = 7'b1000101;
        pad2 = 7'b0000011;
        io_read("R6 even pack", 8'hDC, 8'h3A, 8'h00);
        pad2 = 7'b1010100;
        reset_btn = 1'b1;
        io_read("R7 odd pack", 8'hDD, 8'h2A, 8'h00);

        // R8: home mode balance write ignored
        io_write("R8 home bal strobes", 8'h06, 8'h12, 8'h00);
        expect_item("R8 home bal unchanged", SEL_BAL, 8'hFF);

        // R12: region 3 and region 0 writes ignored
        io_write("R12 region3 write", 8'hC0, 8'h55, 8'h00);
        io_write("R12 region0 write", 8'h3F, 8'h55, 8'h00);

        // Handheld phase
        handheld = 1'b1;
        io_write("R8 hh bal strobes", 8'h06, 8'h5C, 8'h00);
        expect_item("R8 hh bal loaded", SEL_BAL, 8'h5C);
        io_write("R12 port 07 write", 8'h07, 8'h00, 8'h00);
        expect_item("R12 bal kept", SEL_BAL, 8'h5C);

        // R9: start button
        start_btn = 1'b1;
        io_read("R9 start pressed", 8'h00, 8'h7F, 8'h00);
        start_btn = 1'b0;
        io_read("R9 start released", 8'h00, 8'hFF, 8'h00);

        // R10: handheld pad byte, odd port open
        hh_btn = 6'b010001;
        io_read("R10 hh even", 8'hDC, 8'hEE, 8'h00);
        io_read("R10 hh odd", 8'hDD, 8'hFF, 8'h00);

        // R11: opposite directions cancel
        hh_btn = 6'b000011;
        io_read("R11 up down", 8'hDC, 8'hFF, 8'h00);
        hh_btn = 6'b101110;
        io_read("R11 left right", 8'hDC, 8'hDD, 8'h00);

        @(negedge clk);
        idle_bus();
        done = 1'b1;
        report();
        $finish;
    end
endmodule